// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular list of transmit descriptors kept in a small local descriptor store. Each entry holds a 16-bit status word, a 16-bit frame length and a 32-bit buffer address. The host fills entries through a write port and hands each one to the engine by setting its ready flag. The host reads entries back through a combinational read port.

After reset the engine sits in a halted state. A one-cycle pulse on the restart input starts it. It then fetches the descriptor at its current index. If that descriptor is ready, it raises a send request that carries the buffer address, the length and the CRC-append and last-buffer flags. It holds that request to the frame sender until the sender acknowledges. On the acknowledge it writes the status back with ready cleared and the sender's error code merged in, then moves on to the next entry. The entry flagged as wrap closes the ring and sends the engine back to index 0.

When the engine finds an entry that is not ready, it halts again and waits for the next restart pulse. A completed entry that requests an interrupt sets a sticky frame-done event. A clear pulse removes that event.

Top module: `tx_bd_engine`

## Requirements
- R1: After reset, `halted` is 1, `snd_req` is 0, `frame_evt` is 0 and `cur_idx` is 0. Every descriptor reads as all zero, except that the final entry's status reads 16'h2000 (the wrap flag, bit 13).
- R2: A one-cycle `halt_clr` pulse while halted makes the engine leave the halted state on the next clock.
- R3: For a descriptor whose status bit 15 (ready) is set, the engine raises `snd_req` with `snd_ptr` and `snd_len` equal to the entry's pointer and length. `snd_crc` equals status bit 10 and `snd_last` equals status bit 11. All of these stay stable until `snd_ack`.
- R4: On `snd_ack` during a request, the entry's status becomes the old status with bit 15 cleared and bits [ERR_W-1:0] replaced by `snd_err`. Its length and pointer are unchanged, and `snd_req` drops on the next clock.
- R5: After a descriptor completes, `cur_idx` advances by one. If the completed descriptor has status bit 13 (wrap) set, or it is the last entry, `cur_idx` returns to 0.
- R6: When the engine fetches a descriptor with bit 15 clear, it sets `halted`, issues no request and keeps `cur_idx` at that entry.
- R7: Completion of a descriptor with status bit 12 (interrupt) set sets `frame_evt`. The event stays set until a one-cycle `evt_clr` pulse clears it.
- R8: Completion of a descriptor with bit 12 clear leaves `frame_evt` unchanged.
- R9: A host write through the descriptor write port replaces all three fields of the entry, and the new values appear on the read port for that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dsc_wr_en | input | 1 | Host descriptor write strobe |
| dsc_wr_idx | input | IDX_W | Entry being written |
| dsc_wr_status | input | 16 | Status word to write |
| dsc_wr_length | input | 16 | Length to write |
| dsc_wr_ptr | input | 32 | Buffer address to write |
| dsc_rd_idx | input | IDX_W | Entry being read |
| dsc_rd_status | output | 16 | Status of the read entry |
| dsc_rd_length | output | 16 | Length of the read entry |
| dsc_rd_ptr | output | 32 | Buffer address of the read entry |
| halt_clr | input | 1 | Restart pulse |
| halted | output | 1 | Engine is halted |
| cur_idx | output | IDX_W | Descriptor index the engine is on |
| frame_evt | output | 1 | Sticky frame-done event |
| evt_clr | input | 1 | Clears the frame-done event |
| snd_req | output | 1 | Send request to the frame sender |
| snd_ptr | output | 32 | Buffer address of the request |
| snd_len | output | 16 | Frame length of the request |
| snd_crc | output | 1 | Sender must append the frame check sequence |
| snd_last | output | 1 | Buffer ends a frame |
| snd_ack | input | 1 | Sender has finished the request |
| snd_err | input | ERR_W | Error code from the sender, valid with `snd_ack` |

## Verification
The assertions rely on three properties of the inputs. The sender raises `snd_ack` for a single cycle, and only while `snd_req` is high. The host writes only entries the engine does not own, and `halt_clr` and `evt_clr` arrive as one-cycle pulses. The bench's sender model acknowledges only after it has seen a request, and holds `snd_ack` for exactly one cycle. Descriptor writes and restart pulses are issued only while `halted` reads 1 and no request is outstanding.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

    localparam int ST_W  = 16;
    localparam int LEN_W = 16;
    localparam int PTR_W = 32;

    localparam int BIT_READY = 15;
    localparam int BIT_WRAP  = 13;
    localparam int BIT_INTR  = 12;
    localparam int BIT_LAST  = 11;
    localparam int BIT_CRC   = 10;

    typedef struct packed {
        logic [ST_W-1:0]  status;
        logic [LEN_W-1:0] length;
        logic [PTR_W-1:0] ptr;
    } desc_t;

    typedef enum logic [1:0] {
        ENG_HALT  = 2'd0,
        ENG_FETCH = 2'd1,
        ENG_SEND  = 2'd2
    } eng_state_e;

    // status after completion: ready cleared, error field replaced
    function automatic logic [ST_W-1:0] retire_status(
        input logic [ST_W-1:0] st,
        input logic [ST_W-1:0] err,
        input logic [ST_W-1:0] err_mask
    );
        logic [ST_W-1:0] r;
        r = st & ~err_mask;
        r[BIT_READY] = 1'b0;
        return r | (err & err_mask);
    endfunction

    function automatic desc_t init_desc(input logic is_final);
        desc_t d;
        d = '0;
        d.status[BIT_WRAP] = is_final;
        return d;
    endfunction

endpackage

// File: rtl/tbd_desc_mem.sv
module tbd_desc_mem
    import tbd_pkg::*;
#(
    parameter int NUM_DESC = 8,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_widx,
    input  desc_t            host_wdesc,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_widx,
    input  logic [ST_W-1:0]  eng_wstatus,
    input  logic [IDX_W-1:0] host_ridx,
    output desc_t            host_rdesc,
    input  logic [IDX_W-1:0] eng_ridx,
    output desc_t            eng_rdesc
);

    desc_t entries [NUM_DESC];

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_entry
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        localparam logic IS_FINAL = (g == NUM_DESC - 1);
        desc_t entry_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q <= init_desc(IS_FINAL);
            end else if (eng_we && eng_widx == MY_IDX) begin
                entry_q.status <= eng_wstatus;
            end else if (host_we && host_widx == MY_IDX) begin
                entry_q <= host_wdesc;
            end
        end

        assign entries[g] = entry_q;
    end

    assign host_rdesc = entries[host_ridx];
    assign eng_rdesc  = entries[eng_ridx];

endmodule

// File: rtl/tbd_ring_ctrl.sv
module tbd_ring_ctrl
    import tbd_pkg::*;
#(
    parameter int NUM_DESC = 8,
    parameter int IDX_W    = 3,
    parameter int ERR_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt_clr,
    input  desc_t            rd_desc,
    output logic [IDX_W-1:0] idx,
    output logic             halted,
    output logic             snd_req,
    output logic [PTR_W-1:0] snd_ptr,
    output logic [LEN_W-1:0] snd_len,
    output logic             snd_crc,
    output logic             snd_last,
    input  logic             snd_ack,
    input  logic [ERR_W-1:0] snd_err,
    output logic             wb_en,
    output logic [ST_W-1:0]  wb_status,
    output logic             done_intr,
    output logic             cur_wrap
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);
    localparam logic [ST_W-1:0]  ERR_MASK = ST_W'((1 << ERR_W) - 1);

    eng_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    desc_t            held_q;
    logic [IDX_W-1:0] idx_next;

    always_comb begin
        if (held_q.status[BIT_WRAP] || idx_q == LAST_IDX) begin
            idx_next = '0;
        end else begin
            idx_next = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_HALT;
            idx_q   <= '0;
            held_q  <= '0;
        end else begin
            case (state_q)
                ENG_HALT: begin
                    if (halt_clr) state_q <= ENG_FETCH;
                end
                ENG_FETCH: begin
                    if (rd_desc.status[BIT_READY]) begin
                        held_q  <= rd_desc;
                        state_q <= ENG_SEND;
                    end else begin
                        state_q <= ENG_HALT;
                    end
                end
                ENG_SEND: begin
                    if (snd_ack) begin
                        idx_q   <= idx_next;
                        state_q <= ENG_FETCH;
                    end
                end
                default: state_q <= ENG_HALT;
            endcase
        end
    end

    assign idx       = idx_q;
    assign halted    = (state_q == ENG_HALT);
    assign snd_req   = (state_q == ENG_SEND);
    assign snd_ptr   = held_q.ptr;
    assign snd_len   = held_q.length;
    assign snd_crc   = held_q.status[BIT_CRC];
    assign snd_last  = held_q.status[BIT_LAST];
    assign wb_en     = snd_req && snd_ack;
    assign wb_status = retire_status(held_q.status, ST_W'(snd_err), ERR_MASK);
    assign done_intr = wb_en && held_q.status[BIT_INTR];
    assign cur_wrap  = held_q.status[BIT_WRAP];

endmodule

// File: rtl/tbd_evt.sv
module tbd_evt (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/tx_bd_engine.sv
module tx_bd_engine
    import tbd_pkg::*;
#(
    parameter  int NUM_DESC = 8,
    parameter  int ERR_W    = 4,
    localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dsc_wr_en,
    input  logic [IDX_W-1:0] dsc_wr_idx,
    input  logic [15:0]      dsc_wr_status,
    input  logic [15:0]      dsc_wr_length,
    input  logic [31:0]      dsc_wr_ptr,
    input  logic [IDX_W-1:0] dsc_rd_idx,
    output logic [15:0]      dsc_rd_status,
    output logic [15:0]      dsc_rd_length,
    output logic [31:0]      dsc_rd_ptr,
    input  logic             halt_clr,
    output logic             halted,
    output logic [IDX_W-1:0] cur_idx,
    output logic             frame_evt,
    input  logic             evt_clr,
    output logic             snd_req,
    output logic [31:0]      snd_ptr,
    output logic [15:0]      snd_len,
    output logic             snd_crc,
    output logic             snd_last,
    input  logic             snd_ack,
    input  logic [ERR_W-1:0] snd_err
);

    desc_t            host_wdesc;
    desc_t            host_rdesc;
    desc_t            eng_rdesc;
    logic             wb_en;
    logic [ST_W-1:0]  wb_status;
    logic             done_intr;
    logic             cur_wrap;

    assign host_wdesc = '{status: dsc_wr_status, length: dsc_wr_length, ptr: dsc_wr_ptr};

    tbd_desc_mem #(
        .NUM_DESC (NUM_DESC),
        .IDX_W    (IDX_W)
    ) u_mem (
        .clk         (clk),
        .rst         (rst),
        .host_we     (dsc_wr_en),
        .host_widx   (dsc_wr_idx),
        .host_wdesc  (host_wdesc),
        .eng_we      (wb_en),
        .eng_widx    (cur_idx),
        .eng_wstatus (wb_status),
        .host_ridx   (dsc_rd_idx),
        .host_rdesc  (host_rdesc),
        .eng_ridx    (cur_idx),
        .eng_rdesc   (eng_rdesc)
    );

    tbd_ring_ctrl #(
        .NUM_DESC (NUM_DESC),
        .IDX_W    (IDX_W),
        .ERR_W    (ERR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .halt_clr  (halt_clr),
        .rd_desc   (eng_rdesc),
        .idx       (cur_idx),
        .halted    (halted),
        .snd_req   (snd_req),
        .snd_ptr   (snd_ptr),
        .snd_len   (snd_len),
        .snd_crc   (snd_crc),
        .snd_last  (snd_last),
        .snd_ack   (snd_ack),
        .snd_err   (snd_err),
        .wb_en     (wb_en),
        .wb_status (wb_status),
        .done_intr (done_intr),
        .cur_wrap  (cur_wrap)
    );

    tbd_evt u_evt (
        .clk    (clk),
        .rst    (rst),
        .set_i  (done_intr),
        .clr_i  (evt_clr),
        .flag_o (frame_evt)
    );

    assign dsc_rd_status = host_rdesc.status;
    assign dsc_rd_length = host_rdesc.length;
    assign dsc_rd_ptr    = host_rdesc.ptr;

endmodule

// File: rtl/tx_bd_engine_chk.sv
module tx_bd_engine_chk #(
    parameter int NUM_DESC = 8,
    parameter int IDX_W    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             halt_clr,
    input logic             halted,
    input logic [IDX_W-1:0] cur_idx,
    input logic             frame_evt,
    input logic             evt_clr,
    input logic             snd_req,
    input logic [31:0]      snd_ptr,
    input logic [15:0]      snd_len,
    input logic             snd_ack,
    input logic             done_intr,
    input logic             cur_wrap
);

    AST_RESTART_LEAVES_HALT: assert property (@(posedge clk) disable iff (rst)
        halted && halt_clr |=> !halted); // R2

    AST_REQ_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
        snd_req && !snd_ack |=> snd_req && $stable(snd_ptr) && $stable(snd_len)); // R3

    AST_REQ_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        snd_req && snd_ack |=> !snd_req); // R4

    AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (rst)
        snd_req && snd_ack && cur_wrap |=> cur_idx == '0); // R5

    AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (rst)
        {1'b0, cur_idx} < (IDX_W + 1)'(NUM_DESC)); // R5

    AST_HALT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        halted |-> !snd_req); // R6

    AST_EVT_SET: assert property (@(posedge clk) disable iff (rst)
        done_intr |=> frame_evt); // R7

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
        frame_evt && !evt_clr |=> frame_evt); // R7

endmodule

bind tx_bd_engine tx_bd_engine_chk #(
    .NUM_DESC (NUM_DESC),
    .IDX_W    (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .halt_clr  (halt_clr),
    .halted    (halted),
    .cur_idx   (cur_idx),
    .frame_evt (frame_evt),
    .evt_clr   (evt_clr),
    .snd_req   (snd_req),
    .snd_ptr   (snd_ptr),
    .snd_len   (snd_len),
    .snd_ack   (snd_ack),
    .done_intr (done_intr),
    .cur_wrap  (cur_wrap)
);

// File: tb/test_tx_bd_engine.sv
module test_tx_bd_engine;

    localparam int NUM_DESC = 8;
    localparam int ERR_W    = 4;
    localparam int IDX_W    = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             dsc_wr_en = 1'b0;
    logic [IDX_W-1:0] dsc_wr_idx = '0;
    logic [15:0]      dsc_wr_status = '0;
    logic [15:0]      dsc_wr_length = '0;
    logic [31:0]      dsc_wr_ptr = '0;
    logic [IDX_W-1:0] dsc_rd_idx = '0;
    logic [15:0]      dsc_rd_status;
    logic [15:0]      dsc_rd_length;
    logic [31:0]      dsc_rd_ptr;
    logic             halt_clr = 1'b0;
    logic             halted;
    logic [IDX_W-1:0] cur_idx;
    logic             frame_evt;
    logic             evt_clr = 1'b0;
    logic             snd_req;
    logic [31:0]      snd_ptr;
    logic [15:0]      snd_len;
    logic             snd_crc;
    logic             snd_last;
    logic             snd_ack = 1'b0;
    logic [ERR_W-1:0] snd_err = '0;

    always #4 clk = ~clk;

    tx_bd_engine #(.NUM_DESC(NUM_DESC), .ERR_W(ERR_W)) i_tx_bd_engine (.*);

    typedef struct {
        logic [31:0]      ptr;
        logic [15:0]      len;
        logic             crc;
        logic             last;
        logic [ERR_W-1:0] err;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_desc(input int idx, input logic [15:0] st, input logic [15:0] len,
                           input logic [31:0] ptr);
        @(negedge clk);
        dsc_wr_en     = 1'b1;
        dsc_wr_idx    = IDX_W'(idx);
        dsc_wr_status = st;
        dsc_wr_length = len;
        dsc_wr_ptr    = ptr;
        @(negedge clk);
        dsc_wr_en     = 1'b0;
    endtask

    // driver: loads a ready descriptor and queues the request it must produce
    task automatic push_desc(input int idx, input logic [15:0] st, input logic [15:0] len,
                             input logic [31:0] ptr, input logic [ERR_W-1:0] err);
        exp_t e;
        wr_desc(idx, st, len, ptr);
        e.ptr = ptr; e.len = len; e.crc = st[10]; e.last = st[11]; e.err = err;
        exp_q.push_back(e);
    endtask

    task automatic restart_and_wait;
        @(negedge clk);
        halt_clr = 1'b1;
        @(negedge clk);
        halt_clr = 1'b0;
        chk("R2 left halt after restart", {63'd0, halted}, 64'd0);
        for (int i = 0; i < 200 && !halted; i++) @(negedge clk);
    endtask

    task automatic rd_status(input int idx, input logic [15:0] exp, input string tag);
        dsc_rd_idx = IDX_W'(idx);
        #1;
        chk(tag, {48'd0, dsc_rd_status}, {48'd0, exp});
    endtask

    function automatic logic [15:0] retired(input logic [15:0] st, input logic [ERR_W-1:0] err);
        return (st & 16'h7FF0) | {12'd0, err};
    endfunction

    // monitor and sender model: compares each request with the queue head
    initial begin
        forever begin
            @(negedge clk);
            snd_ack = 1'b0;
            if (snd_req) begin
                exp_t e;
                logic [31:0] p0;
                logic [15:0] l0;
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected request", 64'd1, 64'd0);
                    e.err = '0;
                end else begin
                    e = exp_q.pop_front();
                    chk("R3 request ptr", {32'd0, snd_ptr}, {32'd0, e.ptr});
                    chk("R3 request len/crc/last", {46'd0, snd_len, snd_crc, snd_last},
                        {46'd0, e.len, e.crc, e.last});
                end
                p0 = snd_ptr;
                l0 = snd_len;
                @(negedge clk);
                chk("R3 request held", {15'd0, snd_req, snd_ptr, snd_len}, {15'd0, 1'b1, p0, l0});
                snd_err = e.err;
                snd_ack = 1'b1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 halted", {63'd0, halted}, 64'd1);
        chk("R1 no request", {63'd0, snd_req}, 64'd0);
        chk("R1 event clear", {63'd0, frame_evt}, 64'd0);
        chk("R1 index zero", {61'd0, cur_idx}, 64'd0);
        rd_status(0, 16'h0000, "R1 first entry status");
        rd_status(NUM_DESC - 1, 16'h2000, "R1 final entry wrap");

        // R6 empty ring: restart re-halts without any request
        restart_and_wait();
        chk("R6 halted on empty ring", {63'd0, halted}, 64'd1);
        chk("R6 index kept", {61'd0, cur_idx}, 64'd0);

        // R9 host write and read back
        push_desc(0, 16'h8000, 16'd64, 32'h1000_0000, 4'h0);
        rd_status(0, 16'h8000, "R9 status written");
        chk("R9 length/ptr written", {16'd0, dsc_rd_length, dsc_rd_ptr}, {16'd0, 16'd64, 32'h1000_0000});
        push_desc(1, 16'h9000, 16'd100, 32'h1000_0100, 4'h3);
        push_desc(2, 16'h8C00, 16'd1514, 32'h1000_0200, 4'h0);
        restart_and_wait();
        chk("R3 all requests seen", exp_q.size(), 64'd0);
        chk("R6 halted at first non-ready", {61'd0, cur_idx}, 64'd3);
        rd_status(0, retired(16'h8000, 4'h0), "R4 entry0 retired");
        rd_status(1, retired(16'h9000, 4'h3), "R4 entry1 retired with error");
        chk("R4 entry1 length/ptr kept", {16'd0, dsc_rd_length, dsc_rd_ptr}, {16'd0, 16'd100, 32'h1000_0100});
        rd_status(2, retired(16'h8C00, 4'h0), "R4 entry2 retired");
        chk("R7 event set", {63'd0, frame_evt}, 64'd1);
        @(negedge clk);
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
        chk("R7 event cleared", {63'd0, frame_evt}, 64'd0);

        // R5 wrap back to base
        push_desc(3, 16'h8000, 16'd60, 32'h2000_0300, 4'h0);
        push_desc(4, 16'h8000, 16'd61, 32'h2000_0400, 4'h1);
        push_desc(5, 16'h8000, 16'd62, 32'h2000_0500, 4'h0);
        push_desc(6, 16'h8400, 16'd63, 32'h2000_0600, 4'h0);
        push_desc(7, 16'hA800, 16'd64, 32'h2000_0700, 4'h0);
        push_desc(0, 16'h8000, 16'd65, 32'h2000_0000, 4'h5);
        restart_and_wait();
        chk("R5 all requests seen", exp_q.size(), 64'd0);
        chk("R5 index after wrap", {61'd0, cur_idx}, 64'd1);
        rd_status(7, 16'h2800, "R5 wrap entry retired");
        rd_status(0, retired(16'h8000, 4'h5), "R4 entry0 second pass");
        chk("R8 no event without interrupt flag", {63'd0, frame_evt}, 64'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule